// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read-side timing engine of a parallel NOR-style memory. A configuration register picks the read mode. Out of reset the block answers reads asynchronously: the data output follows the address combinationally, which gives a page-style read. After software clears the mode bit, the block runs clocked bursts. A clock edge where chip enable and the address-valid strobe are both low captures the address. The block then waits out a programmable first-access latency and streams 16-bit words from a built-in array model.

During a burst a WAIT line marks the cycles in which the data output holds nothing valid. Its active level is programmable, and it can be set to lead the data by one clock. Fixed bursts of 4, 8 or 16 words either wrap inside their aligned block or run on linearly. A continuous burst runs without end and pauses once, at its first row crossing. A data-hold option keeps each word for two clocks. Addresses in the non-array region return one fixed word for the whole burst.

Top module: `srb_burst_seq`

## Requirements
- R1: After reset the block is in asynchronous mode with WAIT active high. In asynchronous mode `dout` equals the array word of `addr` combinationally, the strobe is ignored, and WAIT is deasserted.
- R2: `wait_oe` is high exactly when `ce_n` and `oe_n` are both low, and low otherwise, which represents a high-impedance WAIT.
- R3: The configuration word uses these bits: [10] WAIT active high, [9] two-clock data hold, [8] early WAIT, [7:5] latency count (codes below 2 act as 2), [4] asynchronous mode, [3] linear (1 = no wrap), [2:0] burst length (001 = 4, 010 = 8, 011 = 16, any other code = continuous). It loads on a clock edge with `cfg_we` high, and that write ends any burst.
- R4: In synchronous mode, a clock edge with `ce_n` and `adv_n` low captures `addr`. The first word is valid on `dout` right after the L-th following edge, where L is the latency. Words then follow one per clock. The array word for address a is {a[7:0], ~a[7:0]} ^ {a[15:8], 8'h00}.
- R5: A fixed burst of N words presents exactly N words. After that, data is invalid and WAIT stays deasserted until the next capture.
- R6: In wrap mode, a fixed burst steps through its N-aligned block modulo N. In linear mode it steps to address +1.
- R7: A continuous burst steps linearly. Before the first word whose address is a multiple of the row size (16 words), it inserts L-1 invalid clocks. Later row crossings in the same burst insert no stall.
- R8: With the two-clock data hold, each word stays on `dout` for two clocks and the address advances at half rate.
- R9: With bit [10] clear, WAIT is active low. With the bit set, WAIT is active high.
- R10: With early WAIT clear, WAIT is asserted in exactly the burst cycles whose data is invalid. With early WAIT set, WAIT leads that pattern by one clock.
- R11: When bit 15 of the address is set (non-array region), the word is {8'hC0, a[7:0]}. The same word repeats for the whole burst length, and no row stall occurs.
- R12: `ce_n` high ends the burst at the next edge. WAIT then stays deasserted until a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 11 | Configuration word |
| adv_n | input | 1 | Address-valid strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| dout | output | 16 | Read data |
| wait_o | output | 1 | WAIT level |
| wait_oe | output | 1 | WAIT drive enable |

## Verification
On every cycle, the assertions check the local relations of the pipeline:

- a lookahead word moves into the output register one clock later;
- an abort clears the output stage;
- a finished fixed burst shows no data;
- the non-array address does not advance;
- counters stay inside the latency window.

Only the bench scenarios can show the whole word order and the WAIT pattern that emerge over a burst. The bench compares them on every clock against a behavioural model. The cases are:

- each burst length in wrap and linear mode;
- a continuous burst crossing two rows;
- two-clock hold combined with active-low, early WAIT;
- a non-array burst;
- a clamped latency code;
- an abort followed by a restart.

// File: rtl/srb_pkg.sv
package srb_pkg;

   // configuration word, MSB first: bit 10 down to bit 0
   typedef struct packed {
      logic       wait_hi;
      logic       hold2;
      logic       wait_early;
      logic [2:0] lat;
      logic       async_mode;
      logic       linear;
      logic [2:0] blen;
   } srb_cfg_t;

   localparam int CFG_W = 11;
   localparam logic [CFG_W-1:0] CFG_RST = 11'h47F;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LAT,
      ST_RUN,
      ST_STALL,
      ST_DONE
   } srb_state_e;

endpackage

// File: rtl/srb_cfg_reg.sv
module srb_cfg_reg
   import srb_pkg::*;
#(
   parameter logic [CFG_W-1:0] RST_VAL = CFG_RST
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output srb_cfg_t         cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg <= srb_cfg_t'(RST_VAL);
      else if (we) cfg <= srb_cfg_t'(wdata);
   end
endmodule

// File: rtl/srb_array_model.sv
module srb_array_model #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] a,
   output logic [15:0]   word,
   output logic          non_array
);
   if (AW < 16) begin : g_bad_aw
      $error("srb_array_model: AW must be at least 16");
   end

   logic [15:0] a16;
   assign a16       = a[15:0];
   assign non_array = a[AW-1];
   assign word      = non_array ? {8'hC0, a16[7:0]}
                                : ({a16[7:0], ~a16[7:0]} ^ {a16[15:8], 8'h00});
endmodule

// File: rtl/srb_addr_step.sv
module srb_addr_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] cur,
   input  logic [2:0]    blen,
   input  logic          linear,
   output logic [AW-1:0] nxt,
   output logic [4:0]    words,
   output logic          cont
);
   localparam int NLEN = 3;

   logic [AW-1:0] wrapped [NLEN];
   logic [1:0]    idx;

   // one wrapped successor per fixed length: 4, 8, 16 words
   for (genvar g = 0; g < NLEN; g++) begin : g_wrap
      localparam int LG = g + 2;
      assign wrapped[g] = {cur[AW-1:LG], cur[LG-1:0] + LG'(1)};
   end

   always_comb begin
      cont  = 1'b0;
      idx   = 2'd0;
      words = 5'd4;
      case (blen)
         3'b001:  begin idx = 2'd0; words = 5'd4;  end
         3'b010:  begin idx = 2'd1; words = 5'd8;  end
         3'b011:  begin idx = 2'd2; words = 5'd16; end
         default: begin cont = 1'b1; words = 5'd0; end
      endcase
      nxt = (!cont && !linear) ? wrapped[idx] : cur + AW'(1);
   end
endmodule

// File: rtl/srb_burst_seq.sv
module srb_burst_seq
   import srb_pkg::*;
#(
   parameter int AW        = 16,
   parameter int ROW_WORDS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             adv_n,
   input  logic             ce_n,
   input  logic             oe_n,
   input  logic [AW-1:0]    addr,
   output logic [15:0]      dout,
   output logic             wait_o,
   output logic             wait_oe
);
   localparam int ROW_LG = $clog2(ROW_WORDS);

   if (ROW_WORDS < 4 || (1 << ROW_LG) != ROW_WORDS) begin : g_bad_row
      $error("srb_burst_seq: ROW_WORDS must be a power of two >= 4");
   end
   if (ROW_LG >= AW) begin : g_bad_row_aw
      $error("srb_burst_seq: row larger than address space");
   end

   srb_cfg_t   cfg;
   srb_state_e st_q;
   logic [AW-1:0] cur_q, nxt;
   logic [2:0]    cnt_q, lat_eff, lat_m2;
   logic [4:0]    cntw_q, blen_words;
   logic          hold_q, crossed_q, a_valid, cont;
   logic [15:0]   a_word, pin_word, b_word;
   logic          cur_na, pin_na;
   logic          b_active, b_valid, a_active, stall_now, kill;

   srb_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
   );
   srb_array_model #(.AW(AW)) u_arr_cur (
      .a(cur_q), .word(a_word), .non_array(cur_na)
   );
   srb_array_model #(.AW(AW)) u_arr_pin (
      .a(addr), .word(pin_word), .non_array(pin_na)
   );
   srb_addr_step #(.AW(AW)) u_step (
      .cur(cur_q), .blen(cfg.blen), .linear(cfg.linear),
      .nxt(nxt), .words(blen_words), .cont(cont)
   );

   assign lat_eff  = (cfg.lat < 3'd2) ? 3'd2 : cfg.lat;
   assign lat_m2   = lat_eff - 3'd2;
   assign kill     = cfg_we | ce_n | cfg.async_mode;
   assign a_active = (st_q == ST_LAT) | (st_q == ST_RUN) | (st_q == ST_STALL);

   // lookahead stage: one clock ahead of the output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; cur_q <= '0; cnt_q <= '0; cntw_q <= '0;
         hold_q <= 1'b0; crossed_q <= 1'b0; a_valid <= 1'b0;
      end else if (kill) begin
         st_q <= ST_IDLE; a_valid <= 1'b0;
      end else if (!adv_n) begin
         st_q <= ST_LAT; cur_q <= addr; cnt_q <= '0; cntw_q <= '0;
         hold_q <= 1'b0; crossed_q <= 1'b0; a_valid <= 1'b0;
      end else begin
         case (st_q)
            ST_LAT, ST_STALL: begin
               if (cnt_q == lat_m2) begin
                  st_q <= ST_RUN; a_valid <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 3'd1;
               end
            end
            ST_RUN: begin
               if (cfg.hold2 && !hold_q) begin
                  hold_q <= 1'b1;
               end else begin
                  hold_q <= 1'b0;
                  if (!cont && cntw_q == blen_words - 5'd1) begin
                     st_q <= ST_DONE; a_valid <= 1'b0;
                  end else begin
                     cntw_q <= cntw_q + 5'd1;
                     if (!cur_na) begin
                        cur_q <= nxt;
                        if (cont && !crossed_q && nxt[ROW_LG-1:0] == '0) begin
                           crossed_q <= 1'b1; st_q <= ST_STALL;
                           cnt_q <= '0; a_valid <= 1'b0;
                        end
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_active <= 1'b0; b_valid <= 1'b0; b_word <= '0;
      end else if (kill) begin
         b_active <= 1'b0; b_valid <= 1'b0;
      end else if (!adv_n) begin
         b_active <= 1'b1; b_valid <= 1'b0;
      end else begin
         b_active <= a_active; b_valid <= a_valid; b_word <= a_word;
      end
   end

   assign stall_now = cfg.wait_early ? (a_active & ~a_valid) : (b_active & ~b_valid);
   assign wait_o    = cfg.wait_hi ? stall_now : ~stall_now;
   assign wait_oe   = ~ce_n & ~oe_n;
   assign dout      = cfg.async_mode ? pin_word : b_word;

   // R12
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (!b_active && !b_valid));

   // R10
   lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_valid && !kill && adv_n) |=> (b_valid && b_word == $past(a_word)));

   // R5
   done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DONE && !kill && adv_n) |=> !b_valid);

   // R11
   non_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && cur_na && !kill && adv_n) |=> (cur_q == $past(cur_q)));

   // R7
   stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_STALL) |-> (crossed_q && cnt_q <= lat_m2));

   // R4
   lat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LAT) |-> (cnt_q <= lat_m2 && !a_valid));

   // R2 / R1
   pin_na_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.async_mode && !pin_na) |-> (dout[7:0] == ~addr[7:0]));

endmodule

// File: tb/srb_burst_seq_test.sv
`timescale 1ns/1ps
module srb_burst_seq_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [10:0] cfg_wdata = '0;
   logic adv_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1;
   logic [15:0] addr = '0;
   logic [15:0] dout;
   logic wait_o, wait_oe;

   int checks = 0, errors = 0;
   bit done = 0;

   bit          exp_v [0:255];
   logic [15:0] exp_w [0:255];

   always #5 clk = ~clk;

   srb_burst_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .adv_n(adv_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
      .dout(dout), .wait_o(wait_o), .wait_oe(wait_oe)
   );

   function automatic logic [15:0] arr_word(input logic [15:0] a);
      if (a[15]) return {8'hC0, a[7:0]};
      return {a[7:0], ~a[7:0]} ^ {a[15:8], 8'h00};
   endfunction

   function automatic logic [10:0] mk_cfg(input bit asy, input int latc, input bit pol,
         input bit hold, input bit wd, input bit lin, input int bl);
      logic [2:0] code;
      code = (bl == 4) ? 3'b001 : (bl == 8) ? 3'b010 : (bl == 16) ? 3'b011 : 3'b111;
      return {pol, hold, wd, 3'(latc), asy, lin, code};
   endfunction

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic write_cfg(input logic [10:0] w);
      @(negedge clk);
      ce_n = 1'b1; cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // reference model: expected output sample k is taken after edge k,
   // edge 0 being the capture edge
   task automatic run_burst(input logic [15:0] a, input int bl, input bit lin,
         input int latc, input bit hold2, input bit pol, input bit wd,
         input int cyc, input string req);
      int L, H, t, last;
      bit crossed;
      logic [15:0] ai;
      L = (latc < 2) ? 2 : latc;
      H = hold2 ? 2 : 1;
      for (int k = 0; k < 256; k++) begin exp_v[k] = 0; exp_w[k] = '0; end
      t = L; crossed = 0;
      for (int i = 0; ; i++) begin
         if (bl != 0 && i == bl) break;
         if (t > cyc + 2) break;
         if (a[15])                    ai = a;
         else if (bl != 0 && !lin)     ai = (a & ~16'(bl - 1)) | ((a + 16'(i)) & 16'(bl - 1));
         else                          ai = a + 16'(i);
         if (bl == 0 && !a[15] && i > 0 && ai[3:0] == 4'h0 && !crossed) begin
            t += L - 1; crossed = 1;
         end
         for (int h = 0; h < H; h++) begin exp_v[t+h] = 1; exp_w[t+h] = arr_word(ai); end
         t += H;
      end
      last = (bl != 0) ? t - 1 : 100000;

      write_cfg(mk_cfg(0, latc, pol, hold2, wd, lin, bl));
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = a;
      @(posedge clk);
      @(negedge clk);
      adv_n = 1'b1; addr = 16'h7777;
      for (int k = 0; k <= cyc; k++) begin
         bit w0, w1, we_, lvl;
         if (k > 0) @(negedge clk);
         w0  = (k <= last) && !exp_v[k];
         w1  = (k + 1 <= last) && !exp_v[k+1];
         we_ = wd ? w1 : w0;
         lvl = pol ? we_ : !we_;
         check(wait_o == lvl, {req, " wait"}, 16'(wait_o), 16'(lvl));
         if (exp_v[k]) check(dout == exp_w[k], {req, " data"}, dout, exp_w[k]);
      end
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 R2: reset state, asynchronous reads
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; addr = 16'h1234;
      #1;
      check(dout == arr_word(16'h1234), "R1 async data", dout, arr_word(16'h1234));
      check(wait_o == 1'b0, "R1 wait idle", 16'(wait_o), 16'h0);
      check(wait_oe == 1'b1, "R2 wait enabled", 16'(wait_oe), 16'h1);
      adv_n = 1'b0;
      @(negedge clk);
      adv_n = 1'b1; addr = 16'h00A7;
      #1;
      check(dout == arr_word(16'h00A7), "R1 strobe ignored", dout, arr_word(16'h00A7));
      check(wait_o == 1'b0, "R1 wait after strobe", 16'(wait_o), 16'h0);
      oe_n = 1'b1;
      #1;
      check(wait_oe == 1'b0, "R2 oe high", 16'(wait_oe), 16'h0);
      ce_n = 1'b1; oe_n = 1'b0;
      #1;
      check(wait_oe == 1'b0, "R2 ce high", 16'(wait_oe), 16'h0);
      oe_n = 1'b1;

      // R4 R5 R6: fixed lengths, wrap and linear
      foreach (exp_v[i]) exp_v[i] = 0;
      run_burst(16'h0105, 4,  0, 3, 0, 1, 0, 14, "R4 R5 R6 bl4 wrap");
      run_burst(16'h0105, 4,  1, 3, 0, 1, 0, 14, "R4 R5 R6 bl4 lin");
      run_burst(16'h0105, 8,  0, 3, 0, 1, 0, 18, "R5 R6 bl8 wrap");
      run_burst(16'h0105, 8,  1, 3, 0, 1, 0, 18, "R5 R6 bl8 lin");
      run_burst(16'h010B, 16, 0, 3, 0, 1, 0, 26, "R5 R6 bl16 wrap");
      run_burst(16'h010B, 16, 1, 3, 0, 1, 0, 26, "R5 R6 bl16 lin");
      // R7: continuous, two row crossings, stall only on the first
      run_burst(16'h0109, 0, 1, 4, 0, 1, 0, 50, "R7 cont");
      // R8 R9 R10: hold two clocks, active-low, early WAIT
      run_burst(16'h00FC, 0, 1, 2, 1, 0, 1, 60, "R8 R9 R10 cont");
      run_burst(16'h0033, 8, 0, 5, 0, 1, 1, 20, "R10 early bl8");
      run_burst(16'h0041, 4, 1, 3, 1, 0, 0, 20, "R8 R9 bl4");
      // R3: latency code 0 acts as 2
      run_burst(16'h0200, 4, 1, 0, 0, 1, 0, 10, "R3 lat clamp");
      // R11: non-array region
      run_burst(16'h8003, 8, 0, 3, 0, 1, 0, 16, "R11 bl8");
      run_burst(16'h80F0, 0, 1, 3, 0, 1, 0, 30, "R11 cont");

      // R12: abort then idle, then a fresh burst
      write_cfg(mk_cfg(0, 3, 1, 0, 0, 1, 0));
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 16'h0200;
      @(negedge clk);
      adv_n = 1'b1;
      repeat (5) @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      check(wait_oe == 1'b0, "R12 wait off", 16'(wait_oe), 16'h0);
      ce_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(wait_o == 1'b0, "R12 idle after abort", 16'(wait_o), 16'h0);
      end
      ce_n = 1'b1; oe_n = 1'b1;
      run_burst(16'h0300, 16, 1, 3, 0, 1, 0, 22, "R12 restart");

      // R1 R3: back to asynchronous mode
      write_cfg(mk_cfg(1, 3, 1, 0, 0, 1, 0));
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; addr = 16'h4C21;
      #1;
      check(dout == arr_word(16'h4C21), "R1 R3 async again", dout, arr_word(16'h4C21));
      addr = 16'h8055;
      #1;
      check(dout == 16'hC055, "R11 async non-array", dout, 16'hC055);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule